// File: doc/BRIEF.md
# Link Health Monitor with Stall Recovery

This block decides, on request, whether a serial link is healthy. It samples two status flags from the link controller: link-up and in-training. A link that is up and has finished training is reported good at once. A link that is up but still training is sampled again after a fixed gap, up to a bounded number of times. A link that is down, or one that never leaves training within that window, goes on to a stall test.

The stall test looks for one known hang in a speed transition. The hang is present when the 6-bit training-state field reads 6'h0D (receiver-lock recovery) and the PHY receive-valid bit is low. When the hang is found, the block raises two receiver override controls for a fixed hold time and then drops them. These are a receive-data enable (bit 5 of the override word) and a receive-PLL enable (bit 3). All other override bits pass through from the current PHY override value, so the write is a read-modify-write. A one-cycle event and a saturating counter record each recovery. The result of any evaluation that does not pass is "not OK".

FSM states: LW_IDLE (waits for a request), LW_SAMPLE (reads the flags), LW_GAP (waits between samples), LW_STALL_CHK (tests for the hang), LW_RECOVER (holds the overrides), LW_PASS and LW_FAIL (one-cycle result states). Transitions:
- idle to sample on request;
- sample to pass when the link is up and not training;
- sample to stall-check when the link is down or the window is used up;
- sample to gap otherwise;
- gap to sample when the gap ends;
- stall-check to recover on the hang, otherwise to fail;
- recover to fail when the hold ends;
- pass and fail back to idle.

Top module: `link_watch`

## Requirements
- R1: After reset, done, link_ok, stall_evt, both override controls and stall_cnt are 0, and ovrd_word equals ovrd_base with bits 5 and 3 cleared.
- R2: With link_up=1 and in_training=0, done rises 2 cycles after the request edge with link_ok=1, and ltssm_state and rx_valid have no effect.
- R3: With link_up=0, no polling happens: done rises 3 cycles after the request edge, and link_ok=0 unless a stall is found.
- R4: With link_up=1 and in_training=1, the flags are sampled again every GAP_CYCLES+1 cycles. If training clears, the result is link_ok=1 one cycle after the sample that sees it.
- R5: After POLL_LIMIT re-samples that all still show training, the block goes to the stall test. Without a stall, done rises 3+POLL_LIMIT*(GAP_CYCLES+1) cycles after the request with link_ok=0.
- R6: A stall is declared only when ltssm_state equals 6'h0D exactly and rx_valid=0. Any other combination gives link_ok=0 with no recovery.
- R7: On a stall, rx_data_ovrd (override bit 5) and rx_pll_ovrd (override bit 3) are both 1 for exactly HOLD_CYCLES cycles. The result that follows is link_ok=0, HOLD_CYCLES cycles later than without a stall.
- R8: In ovrd_word, bits 5 and 3 are 1 during recovery and 0 otherwise; every other bit equals ovrd_base.
- R9: stall_evt is a one-cycle pulse in the first recovery cycle. stall_cnt counts these pulses and saturates at 2^CNT_W-1.
- R10: eval_req is ignored while an evaluation or recovery is in progress; no second result follows.
- R11: done is a one-cycle pulse, and link_ok changes only in a cycle where done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_req | input | 1 | Start one evaluation (taken only when idle) |
| link_up | input | 1 | Link-up flag from the controller |
| in_training | input | 1 | Link-training-in-progress flag |
| ltssm_state | input | ST_W | Training state machine state |
| rx_valid | input | 1 | PHY receive-valid bit |
| ovrd_base | input | OVRD_W | Current PHY receiver override word |
| done | output | 1 | One-cycle result strobe |
| link_ok | output | 1 | Result of the last evaluation |
| stall_evt | output | 1 | One-cycle pulse at the start of a recovery |
| stall_cnt | output | CNT_W | Saturating count of recoveries |
| rx_data_ovrd | output | 1 | Receive-data enable override control |
| rx_pll_ovrd | output | 1 | Receive-PLL enable override control |
| ovrd_word | output | OVRD_W | Override word to write back to the PHY |

## Verification
The checker watches several relations on every cycle. A recovery always opens with a stall event and both override controls high. A recovery always closes with a not-OK result. The result strobe lasts one cycle, and link_ok moves only with it. The counter never goes down, and it steps by one after each event until it saturates. Other properties need the bench's scenarios. These are the exact latencies of the pass, link-down, exhausted-window and recovery paths, the hold length, and the exact 6'h0D match. The bench also shows that requests made mid-recovery are dropped, that the window accepts a training flag which clears late, and that the other override bits pass through.

// File: rtl/link_watch_pkg.sv
package link_watch_pkg;

    typedef enum logic [2:0] {
        LW_IDLE,
        LW_SAMPLE,
        LW_GAP,
        LW_STALL_CHK,
        LW_RECOVER,
        LW_PASS,
        LW_FAIL
    } lw_state_e;

endpackage

// File: rtl/lw_span_counter.sv
// Counts enabled cycles from zero; hit flags the last count of a span of LIMIT.
module lw_span_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/lw_stall_match.sv
// Flags the known speed-transition hang: recovery receiver-lock with no valid data.
module lw_stall_match #(
    parameter int ST_W       = 6,
    parameter int STUCK_CODE = 13
) (
    input  logic [ST_W-1:0] ltssm_state,
    input  logic            rx_valid,
    output logic            stuck
);
    localparam logic [ST_W-1:0] STUCK_VAL = ST_W'(STUCK_CODE);

    always_comb begin
        stuck = (ltssm_state == STUCK_VAL) && !rx_valid;
    end
endmodule

// File: rtl/lw_ovrd_merge.sv
// Read-modify-write of the override word: two bits forced, the rest pass through.
module lw_ovrd_merge #(
    parameter int OVRD_W      = 16,
    parameter int DATA_EN_BIT = 5,
    parameter int PLL_EN_BIT  = 3
) (
    input  logic [OVRD_W-1:0] base,
    input  logic              force_on,
    output logic [OVRD_W-1:0] word
);
    for (genvar i = 0; i < OVRD_W; i++) begin : g_bit
        if (i == DATA_EN_BIT || i == PLL_EN_BIT) begin : g_forced
            assign word[i] = force_on;
        end else begin : g_pass
            assign word[i] = base[i];
        end
    end
endmodule

// File: rtl/lw_sat_count.sv
module lw_sat_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/link_watch.sv
module link_watch
    import link_watch_pkg::*;
#(
    parameter int POLL_LIMIT  = 500,
    parameter int GAP_CYCLES  = 1250,
    parameter int HOLD_CYCLES = 250000,
    parameter int ST_W        = 6,
    parameter int STUCK_CODE  = 13,
    parameter int OVRD_W      = 16,
    parameter int DATA_EN_BIT = 5,
    parameter int PLL_EN_BIT  = 3,
    parameter int CNT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_req,
    input  logic              link_up,
    input  logic              in_training,
    input  logic [ST_W-1:0]   ltssm_state,
    input  logic              rx_valid,
    input  logic [OVRD_W-1:0] ovrd_base,
    output logic              done,
    output logic              link_ok,
    output logic              stall_evt,
    output logic [CNT_W-1:0]  stall_cnt,
    output logic              rx_data_ovrd,
    output logic              rx_pll_ovrd,
    output logic [OVRD_W-1:0] ovrd_word
);
    localparam int POLL_SPAN = POLL_LIMIT + 1;

    lw_state_e state_q, state_d;
    logic      gap_hit, poll_hit, hold_hit, stuck;
    logic      link_ok_q, stall_evt_q, recovering;

    // Spacing between samples of the training flag.
    lw_span_counter #(.LIMIT(GAP_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != LW_GAP),
        .en    (state_q == LW_GAP),
        .hit   (gap_hit)
    );

    // Number of re-samples taken in this evaluation.
    lw_span_counter #(.LIMIT(POLL_SPAN)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == LW_IDLE),
        .en    (state_q == LW_SAMPLE && state_d == LW_GAP),
        .hit   (poll_hit)
    );

    // Length of the receiver override pulse.
    lw_span_counter #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != LW_RECOVER),
        .en    (state_q == LW_RECOVER),
        .hit   (hold_hit)
    );

    lw_stall_match #(.ST_W(ST_W), .STUCK_CODE(STUCK_CODE)) u_match (
        .ltssm_state (ltssm_state),
        .rx_valid    (rx_valid),
        .stuck       (stuck)
    );

    lw_ovrd_merge #(
        .OVRD_W      (OVRD_W),
        .DATA_EN_BIT (DATA_EN_BIT),
        .PLL_EN_BIT  (PLL_EN_BIT)
    ) u_merge (
        .base     (ovrd_base),
        .force_on (recovering),
        .word     (ovrd_word)
    );

    lw_sat_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stall_evt_q),
        .count (stall_cnt)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LW_IDLE: begin
                if (eval_req) state_d = LW_SAMPLE;
            end
            LW_SAMPLE: begin
                if (!link_up)          state_d = LW_STALL_CHK;
                else if (!in_training) state_d = LW_PASS;
                else if (poll_hit)     state_d = LW_STALL_CHK;
                else                   state_d = LW_GAP;
            end
            LW_GAP: begin
                if (gap_hit) state_d = LW_SAMPLE;
            end
            LW_STALL_CHK: begin
                state_d = stuck ? LW_RECOVER : LW_FAIL;
            end
            LW_RECOVER: begin
                if (hold_hit) state_d = LW_FAIL;
            end
            LW_PASS: state_d = LW_IDLE;
            LW_FAIL: state_d = LW_IDLE;
            default: state_d = LW_IDLE;
        endcase
    end

    // Registered outputs: result and stall event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_ok_q   <= 1'b0;
            stall_evt_q <= 1'b0;
        end else begin
            if (state_d == LW_PASS)      link_ok_q <= 1'b1;
            else if (state_d == LW_FAIL) link_ok_q <= 1'b0;
            stall_evt_q <= (state_q == LW_STALL_CHK) && (state_d == LW_RECOVER);
        end
    end

    // State-decoded outputs.
    always_comb begin
        recovering   = (state_q == LW_RECOVER);
        done         = (state_q == LW_PASS) || (state_q == LW_FAIL);
        link_ok      = link_ok_q;
        stall_evt    = stall_evt_q;
        rx_data_ovrd = recovering;
        rx_pll_ovrd  = recovering;
    end
endmodule

// File: rtl/link_watch_chk.sv
module link_watch_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             link_ok,
    input logic             stall_evt,
    input logic [CNT_W-1:0] stall_cnt,
    input logic             rx_data_ovrd,
    input logic             rx_pll_ovrd
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // R9
    evt_opens_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_evt |-> (rx_data_ovrd && rx_pll_ovrd));

    // R7
    ovrd_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_data_ovrd) |-> stall_evt);

    // R7
    recovery_ends_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_pll_ovrd) |-> (done && !link_ok));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    ok_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_ok) |-> done);

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_evt |=> (stall_cnt == $past(stall_cnt) + 1'b1) || ($past(stall_cnt) == CNT_TOP));

    // R9
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stall_cnt >= $past(stall_cnt));

    // R7
    no_ovrd_on_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && link_ok) |-> !(rx_data_ovrd || rx_pll_ovrd));
endmodule

bind link_watch link_watch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .link_ok      (link_ok),
    .stall_evt    (stall_evt),
    .stall_cnt    (stall_cnt),
    .rx_data_ovrd (rx_data_ovrd),
    .rx_pll_ovrd  (rx_pll_ovrd)
);

// File: tb/sim_link_watch.sv
`timescale 1ns/1ps
module sim_link_watch;
    localparam int LIM  = 4;
    localparam int GAP  = 3;
    localparam int HOLD = 12;
    localparam int CW   = 2;
    localparam logic [15:0] BASE = 16'hA5C2;
    localparam logic [15:0] MASK = 16'h0028;

    // {link_up, in_training, ltssm[5:0], rx_valid}
    localparam logic [8:0] VEC [8] = '{
        {1'b1, 1'b0, 6'h00, 1'b1},
        {1'b1, 1'b0, 6'h0D, 1'b0},
        {1'b0, 1'b0, 6'h11, 1'b0},
        {1'b0, 1'b1, 6'h0D, 1'b0},
        {1'b0, 1'b0, 6'h0D, 1'b1},
        {1'b1, 1'b1, 6'h0C, 1'b0},
        {1'b1, 1'b1, 6'h0D, 1'b0},
        {1'b0, 1'b0, 6'h2D, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eval_req = 1'b0, link_up = 1'b0, in_training = 1'b0, rx_valid = 1'b1;
    logic [5:0] ltssm_state = '0;
    logic [15:0] ovrd_base = BASE;
    logic done, link_ok, stall_evt, rx_data_ovrd, rx_pll_ovrd;
    logic [CW-1:0] stall_cnt;
    logic [15:0] ovrd_word;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    link_watch #(
        .POLL_LIMIT(LIM), .GAP_CYCLES(GAP), .HOLD_CYCLES(HOLD), .CNT_W(CW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .link_up(link_up),
        .in_training(in_training), .ltssm_state(ltssm_state), .rx_valid(rx_valid),
        .ovrd_base(ovrd_base), .done(done), .link_ok(link_ok), .stall_evt(stall_evt),
        .stall_cnt(stall_cnt), .rx_data_ovrd(rx_data_ovrd), .rx_pll_ovrd(rx_pll_ovrd),
        .ovrd_word(ovrd_word)
    );

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Runs one evaluation; reports latency, override cycles, event cycles,
    // and override-word mismatches. clr_at/req_at: negedge indices for side stimulus.
    task automatic run_eval(input logic [8:0] v, input int clr_at, input int req_at,
                            output int lat, output int ov, output int ev, output int bad);
        @(negedge clk);
        {link_up, in_training, ltssm_state, rx_valid} = v;
        eval_req = 1'b1;
        @(negedge clk);
        eval_req = 1'b0;
        lat = 1; ov = 0; ev = 0; bad = 0;
        while (!done && lat < 500) begin
            if (rx_data_ovrd && rx_pll_ovrd) begin
                ov++;
                if (ovrd_word != (BASE | MASK)) bad++;
            end else if (ovrd_word != (BASE & ~MASK)) begin
                bad++;
            end
            if (stall_evt) ev++;
            if (lat == clr_at) in_training = 1'b0;
            eval_req = (lat == req_at);
            @(negedge clk);
            lat++;
        end
        eval_req = 1'b0;
    endtask

    function automatic int exp_latency(input logic [8:0] v);
        logic stall;
        int base_lat;
        stall = (v[6:1] == 6'h0D) && !v[0];
        if (v[8] && !v[7]) return 2;
        base_lat = v[8] ? 3 + LIM * (GAP + 1) : 3;
        return stall ? base_lat + HOLD : base_lat;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int lat, ov, ev, bad, exp_stalls;
        logic stall_exp, ok_exp;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !link_ok && !stall_evt, "R1 outputs idle", {done, link_ok, stall_evt}, 0);
        check(!rx_data_ovrd && !rx_pll_ovrd, "R1 overrides off", {rx_data_ovrd, rx_pll_ovrd}, 0);
        check(stall_cnt == 0, "R1 stall_cnt", stall_cnt, 0);
        check(ovrd_word == (BASE & ~MASK), "R1 R8 ovrd_word", ovrd_word, BASE & ~MASK);
        rst_n = 1'b1;

        exp_stalls = 0;
        for (int i = 0; i < 8; i++) begin
            stall_exp = (VEC[i][6:1] == 6'h0D) && !VEC[i][0] && !(VEC[i][8] && !VEC[i][7]);
            ok_exp    = VEC[i][8] && !VEC[i][7];
            run_eval(VEC[i], -1, -1, lat, ov, ev, bad);
            if (stall_exp) exp_stalls++;
            // R2 R3 R5 R6 R7: latency by path
            check(lat == exp_latency(VEC[i]), $sformatf("R2 R3 R5 R7 latency row %0d", i), lat, exp_latency(VEC[i]));
            check(link_ok == ok_exp, $sformatf("R2 R6 link_ok row %0d", i), link_ok, ok_exp);
            // R6 R7: recovery only on exact hang, for HOLD cycles
            check(ov == (stall_exp ? HOLD : 0), $sformatf("R6 R7 override cycles row %0d", i), ov, stall_exp ? HOLD : 0);
            // R9: single event per recovery
            check(ev == (stall_exp ? 1 : 0), $sformatf("R9 event row %0d", i), ev, stall_exp ? 1 : 0);
            // R8: override word merge
            check(bad == 0, $sformatf("R8 ovrd_word row %0d", i), bad, 0);
            @(negedge clk);
            check(!done, $sformatf("R11 done one cycle row %0d", i), done, 0);
        end
        check(stall_cnt == exp_stalls, "R9 stall_cnt after table", stall_cnt, exp_stalls);

        // R4: training clears at negedge 6; samples at 1,5,9 -> pass seen at 10
        run_eval({1'b1, 1'b1, 6'h0D, 1'b0}, 6, -1, lat, ov, ev, bad);
        check(lat == 10, "R4 late training clear latency", lat, 10);
        check(link_ok == 1'b1, "R4 late training clear ok", link_ok, 1);
        check(ov == 0, "R4 no recovery", ov, 0);

        // R10: request during recovery is dropped
        run_eval({1'b0, 1'b0, 6'h0D, 1'b0}, -1, 5, lat, ov, ev, bad);
        check(lat == 3 + HOLD, "R10 recovery latency", lat, 3 + HOLD);
        check(link_ok == 1'b0, "R7 result after recovery", link_ok, 0);
        ev = 0;
        for (int k = 0; k < 2 * HOLD; k++) begin
            @(negedge clk);
            if (done || rx_data_ovrd) ev++;
        end
        check(ev == 0, "R10 no second evaluation", ev, 0);
        check(stall_cnt == 3, "R9 stall_cnt three", stall_cnt, 3);

        // R9: saturation at 2^CW-1
        run_eval({1'b1, 1'b1, 6'h0D, 1'b0}, -1, -1, lat, ov, ev, bad);
        @(negedge clk);
        check(ev == 1, "R9 event at saturation", ev, 1);
        check(stall_cnt == 3, "R9 stall_cnt saturates", stall_cnt, 3);
        check(ovrd_word == (BASE & ~MASK), "R8 released word", ovrd_word, BASE & ~MASK);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule